// File: doc/BRIEF.md
# Masked Error Status and Alert Aggregator

This block gathers hardware event indications into two parallel banks of sticky status bits: one bank serves a host processor, the other a management controller. Each bank holds a group of general-purpose input (GPI) error bits, set while the corresponding pin is low, and a group of miscellaneous event bits, such as fan over-limit, fuse or thermal throttle events. Those event bits are set while the corresponding event input is high. An event can set a bit only when it is unmasked. The masks are a global run switch, a per-event mask for each group, and a per-GPI mask that the current sleep state selects.

Each bank has a summary bit that is high whenever any of its status bits is set. An active-low alert output is pulled low while alerting is enabled and either summary bit is high. Software reaches configuration, masks and status through a small synchronous register port. Host status bits are cleared by writing ones. The management bank also clears by writing ones, and it can optionally clear itself when read. All inputs are assumed to be synchronous to `clk`.

Top module: `errAlertAgg`

## Requirements
- R1: After reset every status bit is 0, the configuration register (address 4) reads 0, the per-event masks (addresses 5 and 6) read 0, the three sleep masks (addresses 7, 8, 9) read all ones, and `alertN` is 1.
- R2: While the run bit (bit 0 of address 4) is 0, no event sets any status bit in either bank.
- R3: With run set and no mask active, a low level on `gpioPins[i]` sets bit i of both GPI status registers (host at address 0, management at address 2). A high level on `evtIn[j]` sets bit j of both event status registers (host at address 1, management at address 3).
- R4: A status bit stays set after its event goes away, until it is cleared.
- R5: A one in the GPI mask (address 5) or in the event mask (address 6) stops the matching bit from being set in both banks. Setting a mask bit does not clear a status bit that is already set.
- R6: The sleep field (bits 5:4 of address 4) selects an extra GPI mask: 0 selects none, 1 selects address 7, 2 selects address 8, and 3 selects address 9. Mask registers that are not selected have no effect.
- R7: Writing ones to a status address clears those bits. If an unmasked event is active in the same cycle, the set wins and the bit stays set.
- R8: Address 10 reads bit 0 as the host summary and bit 1 as the management summary. `alertN` is 0 exactly when the alert enable (bit 1 of address 4) is 1 and either summary bit is 1.
- R9: With the clear-on-read bit (bit 2 of address 4) set, a read strobe on address 2 or 3 returns the current value and then clears that register. Host registers never clear on read, and with the bit at 0 a read clears nothing.
- R10: A configuration or mask write takes effect for events from the clock edge after the write edge. An event in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gpioPins | input | NUM_GPI | GPI pin levels; a low level is an error event |
| evtIn | input | NUM_EVT | Miscellaneous event indications, active high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (used only for clear-on-read) |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| alertN | output | 1 | Active-low alert |

## Verification
The bound checker checks four properties on every cycle. A bit never becomes newly set while its effective mask was active, or while the block was in basic mode. A set bit never drops without a clear strobe. An unmasked active event always leaves its bit set on the next cycle, even when a clear arrives with it. A low alert always has some status bit behind it. The bench scenarios are needed for the rest: which mask register each sleep-state code selects, that a newly written mask misses the event in the same cycle, that clear-on-read touches only the management bank and only when enabled, and that enabling a mask leaves an existing bit in place.

// File: rtl/errAlertPkg.sv
package errAlertPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_HOST_GPI = 4'd0;
  localparam logic [ADDR_W-1:0] A_HOST_EVT = 4'd1;
  localparam logic [ADDR_W-1:0] A_MGMT_GPI = 4'd2;
  localparam logic [ADDR_W-1:0] A_MGMT_EVT = 4'd3;
  localparam logic [ADDR_W-1:0] A_CFG      = 4'd4;
  localparam logic [ADDR_W-1:0] A_GPI_MASK = 4'd5;
  localparam logic [ADDR_W-1:0] A_EVT_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] A_SLP1     = 4'd7;
  localparam logic [ADDR_W-1:0] A_SLP3     = 4'd8;
  localparam logic [ADDR_W-1:0] A_SLP45    = 4'd9;
  localparam logic [ADDR_W-1:0] A_SUMMARY  = 4'd10;

  localparam int CFG_RUN   = 0;
  localparam int CFG_ALERT = 1;
  localparam int CFG_COR   = 2;
  localparam int CFG_SLP_LO = 4;

  localparam int NUM_BANKS = 2;  // index 0 = host, 1 = management
  localparam int NUM_SLP_MASKS = 3;

  typedef struct packed {
    logic [NUM_BANKS-1:0][DATA_W-1:0] clrGpi;
    logic [NUM_BANKS-1:0][DATA_W-1:0] clrEvt;
    logic [DATA_W-1:0]                gpiMaskEff;
    logic [DATA_W-1:0]                evtMaskEff;
    logic                             alertEn;
    logic                             runMode;
  } errStrobe_t;
endpackage

// File: rtl/errAlertCtrl.sv
module errAlertCtrl
  import errAlertPkg::*;
#(
  parameter int NUM_GPI = 8,
  parameter int NUM_EVT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [NUM_GPI-1:0]   hostGpi,
  input  logic [NUM_GPI-1:0]   mgmtGpi,
  input  logic [NUM_EVT-1:0]   hostEvt,
  input  logic [NUM_EVT-1:0]   mgmtEvt,
  input  logic                 hostSum,
  input  logic                 mgmtSum,
  output logic [DATA_W-1:0]    regRdata,
  output errStrobe_t           strobe
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic              cfgRun, cfgAlertEn, cfgCor;
  logic [1:0]        cfgSleep;
  logic [DATA_W-1:0] gpiMask, evtMask;
  logic [DATA_W-1:0] slpMask [NUM_SLP_MASKS];
  logic [DATA_W-1:0] slpSel;
  logic [DATA_W-1:0] cfgWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRun     <= 1'b0;
      cfgAlertEn <= 1'b0;
      cfgCor     <= 1'b0;
      cfgSleep   <= 2'd0;
      gpiMask    <= '0;
      evtMask    <= '0;
    end else if (regWr) begin
      if (regAddr == A_CFG) begin
        cfgRun     <= regWdata[CFG_RUN];
        cfgAlertEn <= regWdata[CFG_ALERT];
        cfgCor     <= regWdata[CFG_COR];
        cfgSleep   <= regWdata[CFG_SLP_LO +: 2];
      end
      if (regAddr == A_GPI_MASK) gpiMask <= regWdata;
      if (regAddr == A_EVT_MASK) evtMask <= regWdata;
    end
  end

  for (genvar s = 0; s < NUM_SLP_MASKS; s++) begin : g_slp
    localparam logic [ADDR_W-1:0] MY_ADDR = A_SLP1 + ADDR_W'(s);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           slpMask[s] <= ALL_ONES;
      else if (regWr && regAddr == MY_ADDR) slpMask[s] <= regWdata;
    end
  end

  always_comb begin
    slpSel = '0;
    if (cfgSleep != 2'd0) slpSel = slpMask[cfgSleep - 2'd1];
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[CFG_RUN]          = cfgRun;
    cfgWord[CFG_ALERT]        = cfgAlertEn;
    cfgWord[CFG_COR]          = cfgCor;
    cfgWord[CFG_SLP_LO +: 2]  = cfgSleep;
  end

  always_comb begin
    logic corHit;
    corHit = regRd && cfgCor;
    strobe = '0;
    strobe.runMode    = cfgRun;
    strobe.alertEn    = cfgAlertEn;
    strobe.gpiMaskEff = gpiMask | slpSel | {DATA_W{~cfgRun}};
    strobe.evtMaskEff = evtMask | {DATA_W{~cfgRun}};
    if (regWr && regAddr == A_HOST_GPI) strobe.clrGpi[0] = regWdata;
    if (regWr && regAddr == A_HOST_EVT) strobe.clrEvt[0] = regWdata;
    if (regWr && regAddr == A_MGMT_GPI) strobe.clrGpi[1] = regWdata;
    if (regWr && regAddr == A_MGMT_EVT) strobe.clrEvt[1] = regWdata;
    if (corHit && regAddr == A_MGMT_GPI) strobe.clrGpi[1] = ALL_ONES;
    if (corHit && regAddr == A_MGMT_EVT) strobe.clrEvt[1] = ALL_ONES;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_HOST_GPI: regRdata = DATA_W'(hostGpi);
      A_HOST_EVT: regRdata = DATA_W'(hostEvt);
      A_MGMT_GPI: regRdata = DATA_W'(mgmtGpi);
      A_MGMT_EVT: regRdata = DATA_W'(mgmtEvt);
      A_CFG:      regRdata = cfgWord;
      A_GPI_MASK: regRdata = gpiMask;
      A_EVT_MASK: regRdata = evtMask;
      A_SLP1:     regRdata = slpMask[0];
      A_SLP3:     regRdata = slpMask[1];
      A_SLP45:    regRdata = slpMask[2];
      A_SUMMARY:  regRdata = {{(DATA_W-2){1'b0}}, mgmtSum, hostSum};
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/errAlertDatapath.sv
module errAlertDatapath
  import errAlertPkg::*;
#(
  parameter int NUM_GPI = 8,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GPI-1:0] gpioPins,
  input  logic [NUM_EVT-1:0] evtIn,
  input  errStrobe_t         strobe,
  output logic [NUM_GPI-1:0] hostGpi,
  output logic [NUM_GPI-1:0] mgmtGpi,
  output logic [NUM_EVT-1:0] hostEvt,
  output logic [NUM_EVT-1:0] mgmtEvt,
  output logic               hostSum,
  output logic               mgmtSum,
  output logic               alertN
);
  logic [NUM_GPI-1:0] gpiSet;
  logic [NUM_EVT-1:0] evtSet;
  logic [NUM_GPI-1:0] gpiStat [NUM_BANKS];
  logic [NUM_EVT-1:0] evtStat [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankSum;

  assign gpiSet = ~gpioPins & ~strobe.gpiMaskEff[NUM_GPI-1:0];
  assign evtSet = evtIn & ~strobe.evtMaskEff[NUM_EVT-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gpiStat[b] <= '0;
        evtStat[b] <= '0;
      end else begin
        gpiStat[b] <= (gpiStat[b] & ~strobe.clrGpi[b][NUM_GPI-1:0]) | gpiSet;
        evtStat[b] <= (evtStat[b] & ~strobe.clrEvt[b][NUM_EVT-1:0]) | evtSet;
      end
    end
    assign bankSum[b] = (|gpiStat[b]) | (|evtStat[b]);
  end

  assign hostGpi = gpiStat[0];
  assign mgmtGpi = gpiStat[1];
  assign hostEvt = evtStat[0];
  assign mgmtEvt = evtStat[1];
  assign hostSum = bankSum[0];
  assign mgmtSum = bankSum[1];
  assign alertN  = ~(strobe.alertEn & (|bankSum));
endmodule

// File: rtl/errAlertAgg.sv
module errAlertAgg
  import errAlertPkg::*;
#(
  parameter int NUM_GPI = 8,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GPI-1:0] gpioPins,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               alertN
);
  errStrobe_t         strobe;
  logic [NUM_GPI-1:0] hostGpi, mgmtGpi;
  logic [NUM_EVT-1:0] hostEvt, mgmtEvt;
  logic               hostSum, mgmtSum;

  errAlertCtrl #(.NUM_GPI(NUM_GPI), .NUM_EVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata),
    .hostGpi(hostGpi), .mgmtGpi(mgmtGpi), .hostEvt(hostEvt), .mgmtEvt(mgmtEvt),
    .hostSum(hostSum), .mgmtSum(mgmtSum),
    .regRdata(regRdata), .strobe(strobe)
  );

  errAlertDatapath #(.NUM_GPI(NUM_GPI), .NUM_EVT(NUM_EVT)) u_dp (
    .clk(clk), .rstN(rstN), .gpioPins(gpioPins), .evtIn(evtIn), .strobe(strobe),
    .hostGpi(hostGpi), .mgmtGpi(mgmtGpi), .hostEvt(hostEvt), .mgmtEvt(mgmtEvt),
    .hostSum(hostSum), .mgmtSum(mgmtSum), .alertN(alertN)
  );
endmodule

// File: rtl/errAlertAgg_chk.sv
module errAlertAgg_chk
  import errAlertPkg::*;
#(
  parameter int NUM_GPI = 8,
  parameter int NUM_EVT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_GPI-1:0] gpioPins,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               alertN,
  input errStrobe_t         strobe,
  input logic [NUM_GPI-1:0] hostGpi,
  input logic [NUM_GPI-1:0] mgmtGpi,
  input logic [NUM_EVT-1:0] hostEvt,
  input logic [NUM_EVT-1:0] mgmtEvt
);
  // R5: a bit never rises while its effective mask was active
  p_masked_no_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (((hostGpi & ~$past(hostGpi)) | (mgmtGpi & ~$past(mgmtGpi)))
       & $past(strobe.gpiMaskEff[NUM_GPI-1:0])) == '0);

  p_masked_evt_no_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (((hostEvt & ~$past(hostEvt)) | (mgmtEvt & ~$past(mgmtEvt)))
       & $past(strobe.evtMaskEff[NUM_EVT-1:0])) == '0);

  // R2: nothing new appears while in basic mode
  p_basic_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.runMode) |-> ((hostGpi & ~$past(hostGpi)) == '0 &&
                                (hostEvt & ~$past(hostEvt)) == '0));

  // R4: a set bit only drops under a clear strobe
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(hostGpi) & ~$past(strobe.clrGpi[0][NUM_GPI-1:0]) & ~hostGpi) == '0) &&
    (($past(mgmtEvt) & ~$past(strobe.clrEvt[1][NUM_EVT-1:0]) & ~mgmtEvt) == '0));

  // R7: an unmasked active event wins over any clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(~gpioPins & ~strobe.gpiMaskEff[NUM_GPI-1:0]) & ~(hostGpi & mgmtGpi)) == '0) &&
    (($past(evtIn & ~strobe.evtMaskEff[NUM_EVT-1:0]) & ~(hostEvt & mgmtEvt)) == '0));

  // R8: a low alert always has a status bit and an enable behind it
  p_alert_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    !alertN |-> (strobe.alertEn && ((|hostGpi) || (|mgmtGpi) || (|hostEvt) || (|mgmtEvt))));
endmodule

bind errAlertAgg errAlertAgg_chk #(.NUM_GPI(NUM_GPI), .NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rstN(rstN), .gpioPins(gpioPins), .evtIn(evtIn), .alertN(alertN),
  .strobe(strobe), .hostGpi(hostGpi), .mgmtGpi(mgmtGpi),
  .hostEvt(hostEvt), .mgmtEvt(mgmtEvt)
);

// File: tb/errAlertAgg_bench.sv
`timescale 1ns/1ps
module errAlertAgg_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] gpioPins = 8'hFF;
  logic [7:0] evtIn = 8'h00;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       alertN;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  errAlertAgg u_errAlertAgg (
    .clk(clk), .rstN(rstN), .gpioPins(gpioPins), .evtIn(evtIn),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .alertN(alertN)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] gpio;
    logic [7:0] evt;
    logic [3:0] chkAddr;
    logic [7:0] exp;
    logic       expAlertN;
  } vec_t;

  // Addresses: 0 hostGpi 1 hostEvt 2 mgmtGpi 3 mgmtEvt 4 cfg 5 gpiMask 6 evtMask 7/8/9 sleep masks 10 summary
  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  1'b0, 4'd0, 8'h00, 8'hFE, 8'h00, 4'd0,  8'h00, 1'b1}, // R2 basic mode
    '{4'd10, 1'b1, 4'd4, 8'h03, 8'hFE, 8'h00, 4'd4,  8'h03, 1'b1}, // R10 old run bit
    '{4'd3,  1'b0, 4'd0, 8'h00, 8'hFE, 8'h00, 4'd0,  8'h01, 1'b0}, // R3 gpi set
    '{4'd4,  1'b0, 4'd0, 8'h00, 8'hFF, 8'h00, 4'd2,  8'h01, 1'b0}, // R4 sticky
    '{4'd7,  1'b1, 4'd0, 8'h01, 8'hFF, 8'h00, 4'd0,  8'h00, 1'b0}, // R7 w1c host
    '{4'd8,  1'b1, 4'd2, 8'h01, 8'hFF, 8'h00, 4'd10, 8'h00, 1'b1}, // R8 summary clear
    '{4'd3,  1'b0, 4'd0, 8'h00, 8'hFF, 8'h04, 4'd1,  8'h04, 1'b0}, // R3 event set
    '{4'd7,  1'b1, 4'd1, 8'h04, 8'hFF, 8'h04, 4'd1,  8'h04, 1'b0}, // R7 set wins
    '{4'd10, 1'b1, 4'd6, 8'h04, 8'hFF, 8'h04, 4'd1,  8'h04, 1'b0}, // R10 old mask
    '{4'd5,  1'b1, 4'd1, 8'h04, 8'hFF, 8'h04, 4'd1,  8'h00, 1'b0}, // R5 mask blocks
    '{4'd5,  1'b0, 4'd0, 8'h00, 8'hFF, 8'h04, 4'd3,  8'h04, 1'b0}, // R5 mask keeps bit
    '{4'd7,  1'b1, 4'd3, 8'h04, 8'hFF, 8'h00, 4'd3,  8'h00, 1'b1}, // R7 w1c mgmt
    '{4'd6,  1'b1, 4'd4, 8'h13, 8'hFF, 8'h00, 4'd4,  8'h13, 1'b1}, // R6 sleep 1
    '{4'd6,  1'b0, 4'd0, 8'h00, 8'h7F, 8'h00, 4'd0,  8'h00, 1'b1}, // R6 masked in S1
    '{4'd10, 1'b1, 4'd7, 8'h7F, 8'h7F, 8'h00, 4'd0,  8'h00, 1'b1}, // R10 old sleep mask
    '{4'd6,  1'b0, 4'd0, 8'h00, 8'h7F, 8'h00, 4'd0,  8'h80, 1'b0}, // R6 unmasked in S1
    '{4'd4,  1'b1, 4'd0, 8'h80, 8'hFF, 8'h00, 4'd2,  8'h80, 1'b0}, // R4 mgmt keeps
    '{4'd5,  1'b1, 4'd5, 8'h02, 8'hFF, 8'h00, 4'd5,  8'h02, 1'b0}, // R5 gpi mask reg
    '{4'd5,  1'b0, 4'd0, 8'h00, 8'hFD, 8'h00, 4'd0,  8'h00, 1'b0}, // R5 gpi masked
    '{4'd9,  1'b1, 4'd4, 8'h07, 8'hFF, 8'h00, 4'd2,  8'h80, 1'b0}, // R9 cor on, no clear
    '{4'd6,  1'b1, 4'd4, 8'h27, 8'hFF, 8'h00, 4'd4,  8'h27, 1'b0}, // R6 sleep 2
    '{4'd6,  1'b0, 4'd0, 8'h00, 8'h7F, 8'h00, 4'd0,  8'h00, 1'b0}  // R6 S3 mask selected
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    #0.5;
    check(tag, regRdata, exp);
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdStrobe(input logic [3:0] a);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    peek("R1 hostGpi", 4'd0, 8'h00);
    peek("R1 cfg", 4'd4, 8'h00);
    peek("R1 gpiMask", 4'd5, 8'h00);
    peek("R1 sleep S1 mask", 4'd7, 8'hFF);
    peek("R1 sleep S45 mask", 4'd9, 8'hFF);
    check("R1 alertN", {7'd0, alertN}, 8'h01);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      regWr = TBL[i].wr; regAddr = TBL[i].addr; regWdata = TBL[i].wdata;
      gpioPins = TBL[i].gpio; evtIn = TBL[i].evt;
      @(negedge clk);
      regWr = 1'b0;
      peek($sformatf("R%0d row %0d data", TBL[i].req, i), TBL[i].chkAddr, TBL[i].exp);
      check($sformatf("R%0d row %0d alertN", TBL[i].req, i), {7'd0, alertN}, {7'd0, TBL[i].expAlertN});
    end
    gpioPins = 8'hFF;

    // R8: alert disabled while mgmt bit still set
    wrReg(4'd4, 8'h05);
    check("R8 alert disabled", {7'd0, alertN}, 8'h01);
    peek("R8 summary mgmt only", 4'd10, 8'h02);

    // R9: read-to-clear returns value then clears
    @(negedge clk);
    regRd = 1'b1; regAddr = 4'd2;
    #0.5;
    check("R9 read returns value", regRdata, 8'h80);
    @(negedge clk);
    regRd = 1'b0;
    peek("R9 cleared after read", 4'd2, 8'h00);

    // R9: host bank is not cleared by read
    @(negedge clk);
    gpioPins = 8'hFE;
    @(negedge clk);
    gpioPins = 8'hFF;
    rdStrobe(4'd0);
    peek("R9 host kept on read", 4'd0, 8'h01);

    // R9: without clear-on-read a read leaves mgmt intact
    wrReg(4'd4, 8'h01);
    rdStrobe(4'd2);
    peek("R9 no clear when cor off", 4'd2, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule